// File: doc/BRIEF.md
# Bunch-Crossing Hit Realignment Buffer

This block gathers zero-suppressed hit records from a set of parallel input links and regroups them by bunch-crossing (BC) number. Each record carries a BC tag and a channel number. Because the sending side buffers its data, a record can reach this block a varying number of BCs after its own crossing, and that number changes from event to event. The block does not delay each link by a fixed amount. It stores every accepted record in a circular buffer of BC slots, placing it by the age of its tag relative to a local BC counter.

On every BC strobe the readout side goes back a fixed number of BCs (parameter `OFS`) and releases the whole content of that slot as one group, then clears the slot. Hits in a group come out link by link in ascending order, and in order of arrival within one link. Every group ends with an end-of-BC marker that carries the group's BC number, and the marker appears even when the group is empty. A downstream coincidence stage therefore receives exactly one aligned hit set per BC, at a fixed latency of `OFS` BCs.

A hit whose tag falls outside the live window is dropped and counted as late. A link that sends more than `CAP` hits for one BC loses the excess, and that BC's marker reports an overflow. The link count is a parameter, and 50 links are supported. Storage grows as slots × links × `CAP` entries.

Top module: `bc_realign`

## Requirements
- R1: After reset, `out_vld_o`, `out_eob_o`, `late_o` and `late_cnt_o` are all zero.
- R2: Every accepted `bc_stb_i` releases exactly one group for BC number (new counter value − `OFS`) mod 3564. The group ends with a single cycle of `out_eob_o`=1, with `out_bc_o` holding that number, even when the group has no hits. Hits are marked by `out_vld_o`=1, and `out_vld_o` and `out_eob_o` are never high in the same cycle.
- R3: Within a group, hits leave in ascending `out_link_o` order. Hits from one link leave in the order they arrived. Each hit shows its own `out_ch_o`.
- R4: A hit is evaluated against the counter value present in its own cycle. It is stored if age = (counter − tag) mod 3564 is below `OFS` and the tag is below 3564. Any other valid hit is dropped, sets the sticky `late_o`, and increments the saturating `late_cnt_o` by one.
- R5: A link holds at most `CAP` hits per BC. Any further hit from that link for that BC is discarded, and `out_ovf_o` is 1 in that BC's end-of-BC cycle (otherwise `out_ovf_o` is 0).
- R6: The BC counter advances by one on each accepted strobe and goes from 3563 to 0.
- R7: `bcr_i` sets the BC counter to 0 and discards all stored hits and overflow marks. A strobe or a hit in the same cycle as `bcr_i` is ignored, and a hit in that cycle does not count as late.
- R8: Hits arriving on several links in the same cycle are all stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bc_stb_i | input | 1 | One-cycle pulse per BC |
| bcr_i | input | 1 | BC counter reset, also clears storage |
| hit_vld_i | input | N_LINKS | Record valid, one bit per link |
| hit_bc_i | input | N_LINKS*BC_W | BC tag per link, link 0 in the low bits |
| hit_ch_i | input | N_LINKS*CH_W | Channel number per link, link 0 in the low bits |
| out_vld_o | output | 1 | A released hit is present |
| out_eob_o | output | 1 | End-of-BC marker |
| out_bc_o | output | BC_W | BC number of the group being released |
| out_link_o | output | LINK_W | Link index of the released hit |
| out_ch_o | output | CH_W | Channel number of the released hit |
| out_ovf_o | output | 1 | Overflow of the group, valid with the marker |
| late_o | output | 1 | Sticky flag for a dropped late hit |
| late_cnt_o | output | LATE_W | Saturating count of dropped late hits |

## Verification
The checker assumes that strobes are spaced widely enough for a full release to finish before the next one. That needs `N_LINKS*(CAP+1)+2` cycles, and the checker flags any strobe that arrives while a release is still running. It also assumes that `bcr_i` arrives only while no release is in progress. The stimulus drives one strobe every 24 cycles, which exceeds the worst case of 22 cycles for four links with capacity four. It places every BC reset in the idle tail of a period. Tags are always produced below 3564, either inside the window, at its edge, or just past it, or slightly in the future.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
  localparam int BC_ORBIT = 3564;
  typedef enum logic {RD_IDLE, RD_SCAN} rd_state_e;
endpackage

// File: rtl/bcr_bc_counter.sv
module bcr_bc_counter #(
  parameter int BC_W   = 12,
  parameter int BC_MAX = 3564,
  parameter int SLOT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic              bcr_i,
  output logic [BC_W-1:0]   bc_o,
  output logic [SLOT_W-1:0] slot_o
);
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(BC_MAX - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bc_o   <= '0;
      slot_o <= '0;
    end else if (bcr_i) begin
      bc_o <= '0;
    end else if (stb_i) begin
      bc_o   <= (bc_o == BC_LAST) ? '0 : bc_o + 1'b1;
      slot_o <= slot_o + 1'b1;
    end
  end
endmodule

// File: rtl/bcr_age_check.sv
module bcr_age_check #(
  parameter int BC_W   = 12,
  parameter int BC_MAX = 3564,
  parameter int SLOT_W = 4,
  parameter int OFS    = 8
) (
  input  logic              vld_i,
  input  logic              bcr_i,
  input  logic [BC_W-1:0]   bc_now_i,
  input  logic [SLOT_W-1:0] slot_now_i,
  input  logic [BC_W-1:0]   tag_i,
  output logic              acc_o,
  output logic              late_o,
  output logic [SLOT_W-1:0] slot_o
);
  localparam logic [BC_W:0] MAX_L = (BC_W+1)'(BC_MAX);
  localparam logic [BC_W:0] OFS_L = (BC_W+1)'(OFS);

  logic [BC_W:0] age;
  logic          in_rng;

  always_comb begin
    if (bc_now_i >= tag_i) age = {1'b0, bc_now_i} - {1'b0, tag_i};
    else                   age = {1'b0, bc_now_i} + MAX_L - {1'b0, tag_i};
  end

  assign in_rng = ({1'b0, tag_i} < MAX_L) && (age < OFS_L);
  assign acc_o  = vld_i && !bcr_i && in_rng;
  assign late_o = vld_i && !bcr_i && !in_rng;
  // slot of the tagged BC, counted back from the current ring position
  assign slot_o = slot_now_i - age[SLOT_W-1:0];
endmodule

// File: rtl/bcr_readout.sv
module bcr_readout
  import bcr_pkg::*;
#(
  parameter int N_LINKS = 4,
  parameter int BC_W    = 12,
  parameter int BC_MAX  = 3564,
  parameter int SLOT_W  = 4,
  parameter int OFS     = 8,
  parameter int LINK_W  = 2,
  parameter int IDX_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic [BC_W-1:0]   bc_now_i,
  input  logic [SLOT_W-1:0] slot_now_i,
  input  logic [IDX_W-1:0]  cnt_i,
  output logic [SLOT_W-1:0] rd_slot_o,
  output logic [LINK_W:0]   rd_link_o,
  output logic [IDX_W-1:0]  rd_idx_o,
  output logic [BC_W-1:0]   rd_bc_o,
  output logic              hit_o,
  output logic              eob_o,
  output logic              busy_o
);
  localparam logic [LINK_W:0] LINK_END = (LINK_W+1)'(N_LINKS);

  rd_state_e state_q;
  logic      start_q;
  logic      at_end;
  logic [BC_W-1:0] bc_back;

  assign bc_back = (bc_now_i >= BC_W'(OFS)) ? bc_now_i - BC_W'(OFS)
                                            : bc_now_i + BC_W'(BC_MAX - OFS);
  assign at_end = (state_q == RD_SCAN) && (rd_link_o == LINK_END);
  assign hit_o  = (state_q == RD_SCAN) && !at_end && (rd_idx_o < cnt_i);
  assign eob_o  = at_end;
  assign busy_o = start_q || (state_q == RD_SCAN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= RD_IDLE;
      start_q   <= 1'b0;
      rd_slot_o <= '0;
      rd_link_o <= '0;
      rd_idx_o  <= '0;
      rd_bc_o   <= '0;
    end else begin
      start_q <= start_i && !abort_i;
      if (abort_i) begin
        state_q <= RD_IDLE;
      end else if (start_q) begin
        // counter has already advanced: trail it by OFS
        state_q   <= RD_SCAN;
        rd_slot_o <= slot_now_i - SLOT_W'(OFS);
        rd_bc_o   <= bc_back;
        rd_link_o <= '0;
        rd_idx_o  <= '0;
      end else if (state_q == RD_SCAN) begin
        if (at_end) begin
          state_q <= RD_IDLE;
        end else if (hit_o) begin
          rd_idx_o <= rd_idx_o + 1'b1;
        end else begin
          rd_link_o <= rd_link_o + 1'b1;
          rd_idx_o  <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/bc_realign.sv
module bc_realign
  import bcr_pkg::*;
#(
  parameter int N_LINKS = 4,
  parameter int CH_W    = 8,
  parameter int BC_W    = 12,
  parameter int BC_MAX  = BC_ORBIT,
  parameter int SLOT_W  = 4,
  parameter int CAP     = 4,
  parameter int OFS     = 8,
  parameter int LATE_W  = 16,
  parameter int LINK_W  = (N_LINKS > 1) ? $clog2(N_LINKS) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      bc_stb_i,
  input  logic                      bcr_i,
  input  logic [N_LINKS-1:0]        hit_vld_i,
  input  logic [N_LINKS*BC_W-1:0]   hit_bc_i,
  input  logic [N_LINKS*CH_W-1:0]   hit_ch_i,
  output logic                      out_vld_o,
  output logic                      out_eob_o,
  output logic [BC_W-1:0]           out_bc_o,
  output logic [LINK_W-1:0]         out_link_o,
  output logic [CH_W-1:0]           out_ch_o,
  output logic                      out_ovf_o,
  output logic                      late_o,
  output logic [LATE_W-1:0]         late_cnt_o
);
  localparam int SLOTS = 1 << SLOT_W;
  localparam int CAP_W = (CAP > 1) ? $clog2(CAP) : 1;
  localparam int IDX_W = $clog2(CAP + 1);
  localparam int NL_W  = $clog2(N_LINKS + 1);

  logic [BC_W-1:0]   bc_q;
  logic [SLOT_W-1:0] slot_q;
  logic [N_LINKS-1:0] acc_v, late_v;
  logic [SLOT_W-1:0] wslot [N_LINKS];

  logic [CH_W-1:0]   mem_q [SLOTS][N_LINKS][CAP];
  logic [IDX_W-1:0]  cnt_q [SLOTS][N_LINKS];
  logic [SLOTS-1:0]  ovf_q;

  logic [SLOT_W-1:0] rd_slot;
  logic [LINK_W:0]   rd_link;
  logic [LINK_W-1:0] rd_link_s;
  logic [IDX_W-1:0]  rd_idx;
  logic [BC_W-1:0]   rd_bc;
  logic              rd_hit, rd_eob, rd_busy;

  bcr_bc_counter #(.BC_W(BC_W), .BC_MAX(BC_MAX), .SLOT_W(SLOT_W)) u_cnt (
    .clk_i (clk_i), .rst_ni(rst_ni), .stb_i(bc_stb_i), .bcr_i(bcr_i),
    .bc_o  (bc_q),  .slot_o(slot_q)
  );

  for (genvar l = 0; l < N_LINKS; l++) begin : g_link
    bcr_age_check #(.BC_W(BC_W), .BC_MAX(BC_MAX), .SLOT_W(SLOT_W), .OFS(OFS)) u_age (
      .vld_i     (hit_vld_i[l]),
      .bcr_i     (bcr_i),
      .bc_now_i  (bc_q),
      .slot_now_i(slot_q),
      .tag_i     (hit_bc_i[l*BC_W +: BC_W]),
      .acc_o     (acc_v[l]),
      .late_o    (late_v[l]),
      .slot_o    (wslot[l])
    );
  end

  assign rd_link_s = (rd_link < (LINK_W+1)'(N_LINKS)) ? rd_link[LINK_W-1:0] : '0;

  bcr_readout #(
    .N_LINKS(N_LINKS), .BC_W(BC_W), .BC_MAX(BC_MAX), .SLOT_W(SLOT_W),
    .OFS(OFS), .LINK_W(LINK_W), .IDX_W(IDX_W)
  ) u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (bc_stb_i && !bcr_i),
    .abort_i   (bcr_i),
    .bc_now_i  (bc_q),
    .slot_now_i(slot_q),
    .cnt_i     (cnt_q[rd_slot][rd_link_s]),
    .rd_slot_o (rd_slot),
    .rd_link_o (rd_link),
    .rd_idx_o  (rd_idx),
    .rd_bc_o   (rd_bc),
    .hit_o     (rd_hit),
    .eob_o     (rd_eob),
    .busy_o    (rd_busy)
  );

  // fill counts and overflow marks; accepted writes never target the slot being read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SLOTS; s++)
        for (int l = 0; l < N_LINKS; l++) cnt_q[s][l] <= '0;
      ovf_q <= '0;
    end else if (bcr_i) begin
      for (int s = 0; s < SLOTS; s++)
        for (int l = 0; l < N_LINKS; l++) cnt_q[s][l] <= '0;
      ovf_q <= '0;
    end else begin
      if (rd_eob) begin
        for (int l = 0; l < N_LINKS; l++) cnt_q[rd_slot][l] <= '0;
        ovf_q[rd_slot] <= 1'b0;
      end
      for (int l = 0; l < N_LINKS; l++) begin
        if (acc_v[l]) begin
          if (cnt_q[wslot[l]][l] < IDX_W'(CAP)) cnt_q[wslot[l]][l] <= cnt_q[wslot[l]][l] + 1'b1;
          else                                  ovf_q[wslot[l]] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    for (int l = 0; l < N_LINKS; l++) begin
      if (acc_v[l] && (cnt_q[wslot[l]][l] < IDX_W'(CAP)))
        mem_q[wslot[l]][l][cnt_q[wslot[l]][l][CAP_W-1:0]] <= hit_ch_i[l*CH_W +: CH_W];
    end
  end

  logic [LATE_W:0] late_sum;
  assign late_sum = {1'b0, late_cnt_o} + (LATE_W+1)'(NL_W'($countones(late_v)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      late_o     <= 1'b0;
      late_cnt_o <= '0;
    end else begin
      if (|late_v) late_o <= 1'b1;
      late_cnt_o <= late_sum[LATE_W] ? '1 : late_sum[LATE_W-1:0];
    end
  end

  assign out_vld_o  = rd_hit;
  assign out_eob_o  = rd_eob;
  assign out_bc_o   = rd_bc;
  assign out_link_o = rd_link_s;
  assign out_ch_o   = mem_q[rd_slot][rd_link_s][rd_idx[CAP_W-1:0]];
  assign out_ovf_o  = rd_eob && ovf_q[rd_slot];
endmodule

// File: rtl/bc_realign_chk.sv
module bc_realign_chk #(
  parameter int BC_W   = 12,
  parameter int BC_MAX = 3564,
  parameter int LINK_W = 2,
  parameter int LATE_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bc_stb_i,
  input logic              bcr_i,
  input logic              out_vld_o,
  input logic              out_eob_o,
  input logic [BC_W-1:0]   out_bc_o,
  input logic [LINK_W-1:0] out_link_o,
  input logic              late_o,
  input logic [LATE_W-1:0] late_cnt_o,
  input logic [BC_W-1:0]   bc_q,
  input logic              rd_busy
);
  assert_one_kind_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({out_vld_o, out_eob_o}));
  assert_stb_spacing_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bc_stb_i |-> !rd_busy);
  assert_group_bc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o |=> $stable(out_bc_o));
  assert_link_order_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o |=> (!out_vld_o || (out_link_o >= $past(out_link_o))));
  assert_late_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    late_o |=> late_o);
  assert_late_cnt_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (late_cnt_o >= $past(late_cnt_o)));
  assert_bc_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bc_q < BC_W'(BC_MAX));
  assert_bc_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bc_stb_i && !bcr_i && (bc_q == BC_W'(BC_MAX - 1))) |=> (bc_q == '0));
  assert_bcr_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bcr_i |=> (bc_q == '0));
endmodule

bind bc_realign bc_realign_chk #(
  .BC_W(BC_W), .BC_MAX(BC_MAX), .LINK_W(LINK_W), .LATE_W(LATE_W)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .bc_stb_i(bc_stb_i), .bcr_i(bcr_i),
  .out_vld_o(out_vld_o), .out_eob_o(out_eob_o), .out_bc_o(out_bc_o),
  .out_link_o(out_link_o), .late_o(late_o), .late_cnt_o(late_cnt_o),
  .bc_q(bc_q), .rd_busy(rd_busy)
);

// File: tb/bc_realign_tb_top.sv
module bc_realign_tb_top;
  localparam int N      = 4;
  localparam int CH_W   = 8;
  localparam int BC_W   = 12;
  localparam int BC_MAX = 3564;
  localparam int CAP    = 4;
  localparam int OFS    = 8;
  localparam int P      = 24;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic bc_stb_i = 1'b0, bcr_i = 1'b0;
  logic [N-1:0] hit_vld_i = '0;
  logic [N*BC_W-1:0] hit_bc_i = '0;
  logic [N*CH_W-1:0] hit_ch_i = '0;
  logic out_vld_o, out_eob_o, out_ovf_o, late_o;
  logic [BC_W-1:0] out_bc_o;
  logic [1:0] out_link_o;
  logic [CH_W-1:0] out_ch_o;
  logic [15:0] late_cnt_o;

  always #2 clk = ~clk;

  bc_realign dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .bc_stb_i(bc_stb_i), .bcr_i(bcr_i),
    .hit_vld_i(hit_vld_i), .hit_bc_i(hit_bc_i), .hit_ch_i(hit_ch_i),
    .out_vld_o(out_vld_o), .out_eob_o(out_eob_o), .out_bc_o(out_bc_o),
    .out_link_o(out_link_o), .out_ch_o(out_ch_o), .out_ovf_o(out_ovf_o),
    .late_o(late_o), .late_cnt_o(late_cnt_o)
  );

  int n_chk = 0, n_bad = 0;
  int model_bc = 0, exp_late = 0;
  int exp_ch [BC_MAX][N][CAP];
  int exp_n  [BC_MAX][N];
  bit exp_ovf [BC_MAX];
  int grp_q[$];
  int cap_q[$];
  int prev_eob_bc = -1;
  bit d_v [N];
  int d_tag [N];
  int d_ch [N];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int wrapbc(input int v);
    return ((v % BC_MAX) + BC_MAX) % BC_MAX;
  endfunction

  task automatic clear_model();
    for (int b = 0; b < BC_MAX; b++) begin
      exp_ovf[b] = 1'b0;
      for (int l = 0; l < N; l++) exp_n[b][l] = 0;
    end
  endtask

  task automatic put(input int l, input int age, input int ch);
    d_v[l] = 1'b1; d_tag[l] = wrapbc(model_bc - age); d_ch[l] = ch & 8'hff;
  endtask

  // called at a falling edge; ends at the next falling edge with inputs idle
  task automatic tick(input bit stb, input bit bcr);
    bc_stb_i = stb; bcr_i = bcr;
    for (int l = 0; l < N; l++) begin
      hit_vld_i[l] = d_v[l];
      hit_bc_i[l*BC_W +: BC_W] = BC_W'(d_tag[l]);
      hit_ch_i[l*CH_W +: CH_W] = CH_W'(d_ch[l]);
      if (d_v[l] && !bcr) begin
        int age;
        age = wrapbc(model_bc - d_tag[l]);
        if (age < OFS) begin
          if (exp_n[d_tag[l]][l] < CAP) begin
            exp_ch[d_tag[l]][l][exp_n[d_tag[l]][l]] = d_ch[l];
            exp_n[d_tag[l]][l]++;
          end else exp_ovf[d_tag[l]] = 1'b1;
        end else exp_late++;
      end
    end
    if (bcr) clear_model();
    @(posedge clk);
    if (bcr) model_bc = 0;
    else if (stb) begin
      model_bc = wrapbc(model_bc + 1);
      grp_q.push_back(wrapbc(model_bc - OFS));
    end
    @(negedge clk);
    bc_stb_i = 1'b0; bcr_i = 1'b0; hit_vld_i = '0;
    for (int l = 0; l < N; l++) d_v[l] = 1'b0;
  endtask

  task automatic pad(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0);
  endtask

  task automatic run_bc(input int pct);
    for (int c = 0; c < P; c++) begin
      for (int l = 0; l < N; l++)
        if ($urandom_range(99, 0) < pct)
          put(l, int'($urandom_range(OFS + 1, 0)) - ($urandom_range(19, 0) == 0 ? 3 : 0),
              int'($urandom_range(255, 0)));
      tick(c == 0, 1'b0);
    end
  endtask

  task automatic chk_late(input string req);
    chk(late_cnt_o == 16'(exp_late), req, "late count", int'(late_cnt_o), exp_late);
    chk(late_o == (exp_late > 0), req, "late flag", int'(late_o), int'(exp_late > 0));
  endtask

  // group monitor: R2 marker/BC, R3 order and content, R5 overflow
  always @(negedge clk) begin
    if (rst_ni && out_vld_o) cap_q.push_back(int'(out_link_o) * 256 + int'(out_ch_o));
    if (rst_ni && out_eob_o) begin
      int eb, k;
      if (grp_q.size() == 0) begin
        chk(1'b0, "R2", "unexpected group bc", int'(out_bc_o), -1);
      end else begin
        eb = grp_q.pop_front();
        chk(int'(out_bc_o) == eb, "R2", "group bc", int'(out_bc_o), eb);
        if (prev_eob_bc == BC_MAX - 1)
          chk(out_bc_o == 0, "R6", "bc after 3563", int'(out_bc_o), 0);
        prev_eob_bc = int'(out_bc_o);
        k = 0;
        for (int l = 0; l < N; l++) k += exp_n[eb][l];
        chk(cap_q.size() == k, "R3", "hits in group", cap_q.size(), k);
        k = 0;
        for (int l = 0; l < N; l++)
          for (int j = 0; j < exp_n[eb][l]; j++) begin
            if (k < cap_q.size())
              chk(cap_q[k] == l * 256 + exp_ch[eb][l][j], "R3", "link*256+ch", cap_q[k], l * 256 + exp_ch[eb][l][j]);
            k++;
          end
        chk(out_ovf_o == exp_ovf[eb], "R5", "overflow flag", int'(out_ovf_o), int'(exp_ovf[eb]));
        exp_ovf[eb] = 1'b0;
        for (int l = 0; l < N; l++) exp_n[eb][l] = 0;
      end
      cap_q.delete();
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "ALL", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    clear_model();
    for (int l = 0; l < N; l++) d_v[l] = 1'b0;
    repeat (3) @(negedge clk);
    chk(!out_vld_o && !out_eob_o, "R1", "outputs in reset", int'({out_vld_o, out_eob_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!out_vld_o && !out_eob_o, "R1", "outputs after reset", int'({out_vld_o, out_eob_o}), 0);
    chk_late("R1");

    run_bc(0);
    // R3/R8: mixed link order and a cycle with all links active
    put(3, 1, 8'h31); tick(1'b1, 1'b0);
    put(1, 1, 8'h11); put(2, 1, 8'h21); tick(1'b0, 1'b0);
    put(1, 1, 8'h12); put(0, 1, 8'h01); tick(1'b0, 1'b0);
    for (int l = 0; l < N; l++) put(l, 1, 8'h40 + l);  // R8
    tick(1'b0, 1'b0);
    pad(P - 4);
    // R5: six hits from link 2 for one BC
    tick(1'b1, 1'b0);
    for (int i = 0; i < 6; i++) begin put(2, 0, 8'h90 + i); tick(1'b0, 1'b0); end
    pad(P - 7);
    // R4: window edges and a future tag
    tick(1'b1, 1'b0);
    put(0, OFS, 8'hA0); put(1, OFS + 3, 8'hA1); put(2, -2, 8'hA2); put(3, OFS - 1, 8'hA3);
    tick(1'b0, 1'b0);
    chk_late("R4");
    pad(P - 2);
    for (int b = 0; b < OFS + 2; b++) run_bc(0);
    chk_late("R4");

    for (int b = 0; b < 300; b++) run_bc(12);
    chk_late("R4");

    // R7: stored hits are discarded by the BC reset, strobe and hit in that cycle ignored
    tick(1'b1, 1'b0);
    put(0, 0, 8'hC0); put(3, 1, 8'hC3); tick(1'b0, 1'b0);
    pad(P - 3);
    put(1, 0, 8'hC1); put(2, OFS + 4, 8'hC2);
    tick(1'b1, 1'b1);
    chk_late("R7");
    chk(grp_q.size() == 0, "R7", "strobe with reset ignored", grp_q.size(), 0);
    for (int b = 0; b < OFS + 2; b++) run_bc(0);

    // R6: full orbit with sparse hits, crossing the counter wrap
    for (int b = 0; b < BC_MAX + 6; b++) run_bc(2);
    pad(P);
    chk(grp_q.size() == 0, "R2", "groups left unreleased", grp_q.size(), 0);
    chk_late("R4");
    finish_run();
  end
endmodule